// File: doc/BRIEF.md
# Video Blanking Window Timing Generator

This block produces the horizontal and vertical active-video window for the front end of a digital video encoder. A free-running pixel counter, clocked once per system clock, marks out each line. A line counter advances on every line start and marks out each field. Three byte-addressable programming values set the window. The first is a 10-bit horizontal blanking value. The second is an 8-bit first-active-line number. The third is a 9-bit count of active lines per field. The block derives from them the encoded blanking flag, the vertical blanking flag and a qualifier that tells the pixel, overlay and alpha input ports when a real picture sample is due.

Two sync modes are supported. In master mode the block owns line timing. Its own low-going `hsync_n` marks each line start, and the delay to the first active input sample is trimmed by a separate HSYNC offset input. In slave mode a falling edge on `ext_hsync_n` restarts the line, and the delay uses a fixed trim instead of the offset. All programmed values, the offset and the mode bit are copied into shadow registers at each line start, so a window already under way is never disturbed. A horizontal window FSM with the states `HW_LEAD` (waiting for the first active sample), `HW_ACTIVE` (counting active samples down) and `HW_DONE` (rest of the line) generates the horizontal qualifier. Its transitions are: line start to `HW_LEAD`, or straight to `HW_ACTIVE` when the start position is zero, or straight to `HW_DONE` when the window length is zero; `HW_LEAD` to `HW_ACTIVE` when the start position is reached; `HW_ACTIVE` to `HW_DONE` after the last active sample. A line start overrides every state.

Top module: `vbt_blank_timing`

## Requirements
- R1: After reset the programming registers read back as: address 0 (blanking low byte, bits 7:0) = 0x0C, address 1 (blanking high bits 9:8 in data bits 1:0) = 0x01, address 2 (first active line) = 0x13, address 3 (active-line count bits 7:0) = 0xF1, address 4 (active-line count bit 8 in data bit 0) = 0x00. During reset `hsync_n` and `vsync_n` are low, `hblank` and `vblank` are high and `vid_active` is low.
- R2: Reserved bits read as zero whatever is written: bits 7:2 at address 1 and bits 7:1 at address 4. The other bits at those addresses keep the written value.
- R3: With an even blanking value HB, `hblank` is high for pixel positions 0 to HB-15 of the line (HB-14 clocks) and low for the rest of the line. HB below 14 gives no blanking.
- R4: With an odd blanking value HB, `hblank` is high for HB-15 clocks starting at pixel position 0, so the encoded blanking length is always even.
- R5: In master mode the first active sample (`vid_active` high) falls HB-2-OFS clocks after the line start, where OFS is `hsync_ofs`. The window lasts PIX_PER_LINE minus the blanking length in clocks.
- R6: In slave mode a falling edge of `ext_hsync_n` restarts the line: pixel position 0 (with `hsync_n` low) is the cycle after the clock edge that samples the low level. The first active sample then falls HB-3 clocks after the line start.
- R7: Lines are numbered from 1 at field start. Line L has `vblank` low exactly when VB <= L < VB+VA, where VB is the first-active-line value and VA is the active-line count. `vid_active` is high only when the horizontal window and the vertical window are both open.
- R8: A write to a programming register, or a change of `hsync_ofs` or `slave_mode`, takes effect at the next line start. The line in progress keeps its window.
- R9: `hsync_n` is low for pixel positions 0 to HSYNC_LEN-1 of every line. `vsync_n` is low for the whole of line 1 (HSYNC_LEN must be at least 2).
- R10: An active window that would run past the end of the line is cut at the last pixel position. The next line starts its own window afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one pixel position per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0 to 4) |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| slave_mode | input | 1 | 0 = master timing, 1 = follow `ext_hsync_n` |
| hsync_ofs | input | HB_W | HSYNC offset used in master mode |
| ext_hsync_n | input | 1 | External horizontal sync, active low (slave mode) |
| hsync_n | output | 1 | Line-start sync, low for HSYNC_LEN clocks |
| vsync_n | output | 1 | Field-start sync, low during line 1 |
| hblank | output | 1 | Encoded horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| vid_active | output | 1 | Active-video qualifier for the input ports |

## Verification
The bench builds the block with 64 clocks per line, 12 lines per field and a 4-clock sync pulse. At this size a whole line can be sampled position by position, and a whole field sweep takes under a thousand cycles. The short line brings these cases within reach in a few hundred cycles each: a window cut at the line end, a programmed first line near the field end, and a zero active count. Resetting the block with the default 268-clock blanking value on a 64-clock line also shows that a blanking length longer than the line closes the window completely.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

    typedef enum logic [1:0] {
        HW_LEAD   = 2'd0,
        HW_ACTIVE = 2'd1,
        HW_DONE   = 2'd2
    } hwin_state_t;

    localparam logic [2:0] ADR_HB_LO = 3'd0;
    localparam logic [2:0] ADR_HB_HI = 3'd1;
    localparam logic [2:0] ADR_VB    = 3'd2;
    localparam logic [2:0] ADR_VA_LO = 3'd3;
    localparam logic [2:0] ADR_VA_HI = 3'd4;

    localparam int RST_HB = 268;
    localparam int RST_VB = 19;
    localparam int RST_VA = 241;

endpackage

// File: rtl/vbt_regs.sv
module vbt_regs
    import vbt_pkg::*;
#(
    parameter int HB_W = 10,
    parameter int VB_W = 8,
    parameter int VA_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [2:0]      rd_addr,
    output logic [7:0]      rd_data,
    output logic [HB_W-1:0] hb_q,
    output logic [VB_W-1:0] vb_q,
    output logic [VA_W-1:0] va_q
);

    // R1: reset defaults; R2: only implemented bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_q <= HB_W'(RST_HB);
            vb_q <= VB_W'(RST_VB);
            va_q <= VA_W'(RST_VA);
        end else if (wr_en) begin
            case (wr_addr)
                ADR_HB_LO: hb_q[7:0]      <= wr_data;
                ADR_HB_HI: hb_q[HB_W-1:8] <= wr_data[HB_W-9:0];
                ADR_VB:    vb_q           <= wr_data[VB_W-1:0];
                ADR_VA_LO: va_q[7:0]      <= wr_data;
                ADR_VA_HI: va_q[VA_W-1:8] <= wr_data[VA_W-9:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADR_HB_LO: rd_data = hb_q[7:0];
            ADR_HB_HI: rd_data = 8'(hb_q >> 8);
            ADR_VB:    rd_data = 8'(vb_q);
            ADR_VA_LO: rd_data = va_q[7:0];
            ADR_VA_HI: rd_data = 8'(va_q >> 8);
            default:   rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/vbt_hwin.sv
module vbt_hwin
    import vbt_pkg::*;
#(
    parameter int HC_W = 10,
    parameter int LW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_load,
    input  logic [HC_W-1:0] h_nxt,
    input  logic [LW-1:0]   ld_start,
    input  logic [LW-1:0]   ld_len,
    input  logic [LW-1:0]   cur_start,
    input  logic [LW-1:0]   cur_len,
    output logic            win_o
);

    hwin_state_t state, state_n;
    logic [LW-1:0] rem, rem_n;

    always_comb begin
        state_n = state;
        rem_n   = rem;
        if (line_load) begin
            // R10: every line start opens a fresh window
            if (ld_len == '0) begin
                state_n = HW_DONE;
            end else if (ld_start == '0) begin
                state_n = HW_ACTIVE;
                rem_n   = ld_len;
            end else begin
                state_n = HW_LEAD;
            end
        end else begin
            unique case (state)
                HW_LEAD: begin
                    if (LW'(h_nxt) == cur_start) begin
                        if (cur_len == '0) begin
                            state_n = HW_DONE;
                        end else begin
                            state_n = HW_ACTIVE;
                            rem_n   = cur_len;
                        end
                    end
                end
                HW_ACTIVE: begin
                    if (rem == LW'(1)) state_n = HW_DONE;
                    else               rem_n   = rem - LW'(1);
                end
                HW_DONE: ;
                default: state_n = HW_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HW_LEAD;
            rem   <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
        end
    end

    always_comb begin
        win_o = (state == HW_ACTIVE);
    end

endmodule

// File: rtl/vbt_vline.sv
module vbt_vline #(
    parameter int LINES = 262,
    parameter int VC_W  = 9,
    parameter int LW    = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_load,
    input  logic [LW-1:0]   vb,
    input  logic [LW-1:0]   va,
    output logic [VC_W-1:0] v_cnt,
    output logic            v_act
);

    // R7: lines numbered from 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_cnt <= VC_W'(1);
        end else if (line_load) begin
            if (v_cnt == VC_W'(LINES)) v_cnt <= VC_W'(1);
            else                       v_cnt <= v_cnt + VC_W'(1);
        end
    end

    always_comb begin
        v_act = (LW'(v_cnt) >= vb) && (LW'(v_cnt) < (vb + va));
    end

endmodule

// File: rtl/vbt_blank_timing.sv
module vbt_blank_timing
    import vbt_pkg::*;
#(
    parameter int PIX_PER_LINE    = 858,
    parameter int LINES_PER_FIELD = 262,
    parameter int HSYNC_LEN       = 64,
    parameter int HB_W            = 10,
    parameter int VB_W            = 8,
    parameter int VA_W            = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [2:0]      rd_addr,
    output logic [7:0]      rd_data,
    input  logic            slave_mode,
    input  logic [HB_W-1:0] hsync_ofs,
    input  logic            ext_hsync_n,
    output logic            hsync_n,
    output logic            vsync_n,
    output logic            hblank,
    output logic            vblank,
    output logic            vid_active
);

    localparam int HC_W  = $clog2(PIX_PER_LINE);
    localparam int VC_W  = $clog2(LINES_PER_FIELD + 1);
    localparam int MAXW  = (HB_W > HC_W) ? ((HB_W > VA_W) ? HB_W : VA_W)
                                         : ((HC_W > VA_W) ? HC_W : VA_W);
    localparam int LW    = MAXW + 2;

    logic [HB_W-1:0] hb_q, sh_hb, sh_ofs;
    logic [VB_W-1:0] vb_q, sh_vb;
    logic [VA_W-1:0] va_q, sh_va;
    logic            sh_slv;
    logic            ext_q;
    logic            resync;
    logic            line_load;
    logic [HC_W-1:0] h_cnt, h_nxt;
    logic [VC_W-1:0] v_cnt;
    logic            v_act, h_win;
    logic            at_line_start;
    logic [LW-1:0]   cur_blank, cur_start, cur_len;
    logic [LW-1:0]   ld_blank, ld_start, ld_len;

    // R3, R4: encoded blanking is HB-14 (even) or HB-15 (odd)
    function automatic logic [LW-1:0] f_blank(input logic [LW-1:0] hb);
        if (hb < LW'(14)) return '0;
        return hb - LW'(14) - LW'(hb[0]);
    endfunction

    // R5, R6: start of the input-port window after the line start
    function automatic logic [LW-1:0] f_start(input logic [LW-1:0] hb,
                                              input logic [LW-1:0] ofs,
                                              input logic          slv);
        logic [LW-1:0] sub;
        sub = slv ? LW'(3) : (LW'(2) + ofs);
        return (hb >= sub) ? (hb - sub) : '0;
    endfunction

    function automatic logic [LW-1:0] f_len(input logic [LW-1:0] blank);
        return (blank >= LW'(PIX_PER_LINE)) ? '0 : (LW'(PIX_PER_LINE) - blank);
    endfunction

    vbt_regs #(.HB_W(HB_W), .VB_W(VB_W), .VA_W(VA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .hb_q    (hb_q),
        .vb_q    (vb_q),
        .va_q    (va_q)
    );

    // R6: falling edge of the external sync restarts the line in slave mode
    always_comb begin
        resync    = slave_mode && ext_q && !ext_hsync_n;
        line_load = resync || (h_cnt == HC_W'(PIX_PER_LINE - 1));
        h_nxt     = line_load ? '0 : (h_cnt + HC_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b1;
            h_cnt <= '0;
        end else begin
            ext_q <= ext_hsync_n;
            h_cnt <= h_nxt;
        end
    end

    // R8: shadow copies change only at a line start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hb  <= HB_W'(RST_HB);
            sh_vb  <= VB_W'(RST_VB);
            sh_va  <= VA_W'(RST_VA);
            sh_ofs <= '0;
            sh_slv <= 1'b0;
        end else if (line_load) begin
            sh_hb  <= hb_q;
            sh_vb  <= vb_q;
            sh_va  <= va_q;
            sh_ofs <= hsync_ofs;
            sh_slv <= slave_mode;
        end
    end

    always_comb begin
        cur_blank = f_blank(LW'(sh_hb));
        cur_start = f_start(LW'(sh_hb), LW'(sh_ofs), sh_slv);
        cur_len   = f_len(cur_blank);
        ld_blank  = f_blank(LW'(hb_q));
        ld_start  = f_start(LW'(hb_q), LW'(hsync_ofs), slave_mode);
        ld_len    = f_len(ld_blank);
    end

    vbt_hwin #(.HC_W(HC_W), .LW(LW)) u_hwin (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_load (line_load),
        .h_nxt     (h_nxt),
        .ld_start  (ld_start),
        .ld_len    (ld_len),
        .cur_start (cur_start),
        .cur_len   (cur_len),
        .win_o     (h_win)
    );

    vbt_vline #(.LINES(LINES_PER_FIELD), .VC_W(VC_W), .LW(LW)) u_vline (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_load (line_load),
        .vb        (LW'(sh_vb)),
        .va        (LW'(sh_va)),
        .v_cnt     (v_cnt),
        .v_act     (v_act)
    );

    always_comb begin
        at_line_start = (h_cnt == '0);
        hsync_n       = !(LW'(h_cnt) < LW'(HSYNC_LEN));
        vsync_n       = !(v_cnt == VC_W'(1));
        hblank        = LW'(h_cnt) < cur_blank;
        vblank        = !v_act;
        vid_active    = h_win && v_act;
    end

endmodule

// File: rtl/vbt_blank_timing_chk.sv
module vbt_blank_timing_chk #(
    parameter int HB_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            at_line_start,
    input logic            line_load,
    input logic [HB_W-1:0] sh_hb,
    input logic            hsync_n,
    input logic            vblank,
    input logic            vid_active,
    input logic [2:0]      rd_addr,
    input logic [7:0]      rd_data
);

    // R7: qualifier needs the vertical window
    p_act_vert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vid_active |-> !vblank);

    // R7: vertical flag only moves at a line start
    p_vblank_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank) |-> at_line_start);

    // R8: shadow blanking value holds between line starts
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_load |=> $stable(sh_hb));

    // R9: sync pulse is wider than one clock
    p_hsync_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |=> !hsync_n);

    // R2: reserved bits read zero
    p_rsv_hb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd1) |-> (rd_data[7:2] == 6'd0));

    p_rsv_va_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd4) |-> (rd_data[7:1] == 7'd0));

endmodule

bind vbt_blank_timing vbt_blank_timing_chk #(.HB_W(HB_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .at_line_start (at_line_start),
    .line_load     (line_load),
    .sh_hb         (sh_hb),
    .hsync_n       (hsync_n),
    .vblank        (vblank),
    .vid_active    (vid_active),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data)
);

// File: tb/test_vbt_blank_timing.sv
module test_vbt_blank_timing;

    localparam int PIX   = 64;
    localparam int LINES = 12;
    localparam int HSL   = 4;
    localparam int HB_W  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [2:0]      rd_addr = '0;
    logic [7:0]      rd_data;
    logic            slave_mode = 1'b0;
    logic [HB_W-1:0] hsync_ofs = '0;
    logic            ext_hsync_n = 1'b1;
    logic            hsync_n, vsync_n, hblank, vblank, vid_active;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vbt_blank_timing #(
        .PIX_PER_LINE(PIX), .LINES_PER_FIELD(LINES), .HSYNC_LEN(HSL),
        .HB_W(HB_W), .VB_W(8), .VA_W(9)
    ) i_vbt_blank_timing (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .slave_mode(slave_mode), .hsync_ofs(hsync_ofs),
        .ext_hsync_n(ext_hsync_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .hblank(hblank), .vblank(vblank), .vid_active(vid_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic set_regs(input int hb, input int vb, input int va);
        wr(3'd0, 8'(hb));
        wr(3'd1, 8'(hb >> 8));
        wr(3'd2, 8'(vb));
        wr(3'd3, 8'(va));
        wr(3'd4, 8'(va >> 8));
    endtask

    // returns at the negedge of pixel position 0
    task automatic wait_line_start();
        logic prev;
        @(negedge clk);
        prev = hsync_n;
        forever begin
            @(negedge clk);
            if (prev && !hsync_n) break;
            prev = hsync_n;
        end
    endtask

    task automatic wait_field_start();
        logic prev;
        @(negedge clk);
        prev = vsync_n;
        forever begin
            @(negedge clk);
            if (prev && !vsync_n) break;
            prev = vsync_n;
        end
    endtask

    // called at the negedge of position 0, ends at position PIX-1
    task automatic measure_line(output int f_act, output int n_act,
                                output int n_hbl, output int f_hlow, output int n_hs);
        f_act = -1; n_act = 0; n_hbl = 0; f_hlow = -1; n_hs = 0;
        for (int k = 0; k < PIX; k++) begin
            if (k > 0) @(negedge clk);
            if (vid_active) begin
                n_act++;
                if (f_act < 0) f_act = k;
            end
            if (hblank) n_hbl++;
            else if (f_hlow < 0) f_hlow = k;
            if (!hsync_n && k < HSL) n_hs++;
            if (!hsync_n && k >= HSL) n_hs += 100;
        end
    endtask

    task automatic t_reset();
        int v;
        repeat (3) @(negedge clk);
        chk(hsync_n == 1'b0, "R1 hsync_n in reset", int'(hsync_n), 0);
        chk(vsync_n == 1'b0, "R1 vsync_n in reset", int'(vsync_n), 0);
        chk(hblank == 1'b1, "R1 hblank in reset", int'(hblank), 1);
        chk(vblank == 1'b1, "R1 vblank in reset", int'(vblank), 1);
        chk(vid_active == 1'b0, "R1 vid_active in reset", int'(vid_active), 0);
        rst_n = 1'b1;
        rd(3'd0, v); chk(v == 'h0C, "R1 addr0", v, 'h0C);
        rd(3'd1, v); chk(v == 'h01, "R1 addr1", v, 'h01);
        rd(3'd2, v); chk(v == 'h13, "R1 addr2", v, 'h13);
        rd(3'd3, v); chk(v == 'hF1, "R1 addr3", v, 'hF1);
        rd(3'd4, v); chk(v == 'h00, "R1 addr4", v, 'h00);
    endtask

    task automatic t_reset_window();
        int fa, na, nh, fl, hs;
        // 268-clock blanking on a 64-clock line: window closed (R3, R5)
        wait_line_start();
        measure_line(fa, na, nh, fl, hs);
        chk(na == 0, "R5 default window closed", na, 0);
        chk(nh == PIX, "R3 default blanking fills line", nh, PIX);
    endtask

    task automatic t_reserved();
        int v;
        wr(3'd1, 8'hFF); rd(3'd1, v);
        chk(v == 'h03, "R2 addr1 reserved", v, 'h03);
        wr(3'd4, 8'hFF); rd(3'd4, v);
        chk(v == 'h01, "R2 addr4 reserved", v, 'h01);
        wr(3'd2, 8'h5A); rd(3'd2, v);
        chk(v == 'h5A, "R2 addr2 full byte", v, 'h5A);
    endtask

    task automatic t_hb_even();
        int fa, na, nh, fl, hs;
        slave_mode = 1'b0; hsync_ofs = 10'd12;
        set_regs(30, 1, 12);
        wait_line_start();
        measure_line(fa, na, nh, fl, hs);
        chk(nh == 16 && fl == 16, "R3 even blanking length", nh, 16);
        chk(fa == 16, "R5 master start HB-2-OFS", fa, 16);
        chk(na == 48, "R5 window length", na, 48);
        chk(hs == HSL, "R9 hsync width", hs, HSL);
    endtask

    task automatic t_hb_odd();
        int fa, na, nh, fl, hs;
        set_regs(31, 1, 12);
        wait_line_start();
        measure_line(fa, na, nh, fl, hs);
        chk(nh == 16 && fl == 16, "R4 odd blanking length", nh, 16);
        chk(fa == 17, "R4 odd shifts start", fa, 17);
        chk(na == 47, "R10 window cut at line end", na, 47);
    endtask

    task automatic t_ofs();
        int fa, na, nh, fl, hs;
        hsync_ofs = 10'd4;
        set_regs(30, 1, 12);
        wait_line_start();
        measure_line(fa, na, nh, fl, hs);
        chk(fa == 24, "R5 offset 4 start", fa, 24);
        chk(na == 40, "R10 cut window length", na, 40);
        hsync_ofs = 10'd12;
    endtask

    task automatic t_slave();
        int fa, na, nh, fl, hs;
        slave_mode = 1'b1;
        set_regs(30, 1, 12);
        wait_line_start();
        repeat (30) @(negedge clk);
        chk(hsync_n == 1'b1, "R6 before external edge", int'(hsync_n), 1);
        ext_hsync_n = 1'b0;
        @(negedge clk);
        chk(hsync_n == 1'b0, "R6 line restarted", int'(hsync_n), 0);
        ext_hsync_n = 1'b1;
        measure_line(fa, na, nh, fl, hs);
        chk(fa == 27, "R6 slave start HB-3", fa, 27);
        chk(na == 37, "R6 slave window length", na, 37);
        slave_mode = 1'b0;
        wait_line_start();
    endtask

    task automatic t_update();
        int fa, na, nh, fl, hs;
        hsync_ofs = 10'd12;
        set_regs(30, 1, 12);
        wait_line_start();
        fa = -1; na = 0;
        for (int k = 0; k < PIX; k++) begin
            if (k > 0) @(negedge clk);
            if (vid_active) begin
                na++;
                if (fa < 0) fa = k;
            end
            if (k == 20) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd60;
            end
            if (k == 21) wr_en = 1'b0;
        end
        chk(fa == 16 && na == 48, "R8 current line kept", na, 48);
        @(negedge clk);
        measure_line(fa, na, nh, fl, hs);
        chk(fa == 46, "R8 next line new start", fa, 46);
        chk(na == 18 && nh == 46, "R8 next line new window", na, 18);
    endtask

    task automatic t_vert(input int vb, input int va, input string tag);
        bit exp_vb;
        set_regs(30, vb, va);
        wait_field_start();
        for (int l = 1; l <= LINES; l++) begin
            repeat (20) @(negedge clk);
            exp_vb = !(l >= vb && l < vb + va);
            chk(vblank == exp_vb, {tag, " R7 vblank"}, int'(vblank), int'(exp_vb));
            chk(vid_active == !exp_vb, {tag, " R7 vid_active"}, int'(vid_active), int'(!exp_vb));
            chk(vsync_n == (l != 1), {tag, " R9 vsync_n"}, int'(vsync_n), int'(l != 1));
            repeat (PIX - 20) @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_reset_window();
        t_reserved();
        t_hb_even();
        t_hb_odd();
        t_ofs();
        t_slave();
        t_update();
        t_vert(3, 4, "mid");
        t_vert(10, 5, "tail");
        t_vert(2, 0, "none");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule